// File: doc/BRIEF.md
# Byte-Order Frame Serializer

This block sits between a memory-side data path and a serial transmitter. It takes 64-bit double words, each tagged with start-of-frame and end-of-frame flags, and hands them out one byte per handshake. The order in which the eight bytes of a double word leave depends on a 2-bit ordering mode. Big-endian and swapped orders treat the double word as two 32-bit words and send the upper word first. Munged order treats the whole double word as one unit and sends its least significant byte first.

The ordering mode and the port-size indication are sampled only when a start-of-frame double word is accepted. A change made while a frame is in flight therefore applies from the next frame. Swapped order needs a 32-bit memory port. If it is requested on any other port size, the block raises a configuration error for that frame and sends the frame in big-endian order. On the final double word of a frame, a byte count limits how many bytes are sent, and the end-of-frame marker travels with the last byte sent.

Top module: `byte_order_serializer`

## Requirements
- R1: With `mode_sel` equal to 2'b10 or 2'b11, the byte of bits 63:56 goes out first, then 55:48, and so on down to bits 7:0.
- R2: With `mode_sel` equal to 2'b00 and `port_is_32` high, the bytes go out as bits 39:32, 47:40, 55:48, 63:56, then 7:0, 15:8, 23:16, 31:24.
- R3: With `mode_sel` equal to 2'b01, the bytes go out as bits 7:0 first, rising one byte each step, with bits 63:56 last.
- R4: `mode_sel` and `port_is_32` are sampled only in the cycle a double word with `in_sof` high is accepted. Changes while a frame is in progress have no effect on that frame's byte order.
- R5: When a frame starts with `mode_sel` 2'b00 and `port_is_32` low, `cfg_err` is high from the next cycle until the next start-of-frame acceptance, and that frame uses R1 order. A start with any other setting clears `cfg_err`.
- R6: On a double word with `in_eof` high, only the first `in_nbytes` bytes of the active order are sent (1 to 8; 0 or values above 8 mean 8). `in_nbytes` is ignored on other double words. `out_eof` marks the last byte sent for an end-of-frame word, and `out_sof` marks the first byte of a start-of-frame word.
- R7: While `out_ready` is low, `out_valid`, `out_byte`, `out_sof` and `out_eof` hold their values. Every accepted byte leaves exactly once and in order.
- R8: `in_ready` is high exactly when no byte of the current double word is still pending (`out_valid` low). An accepted double word presents its first byte in the next cycle.
- R9: After reset, `out_valid` and `cfg_err` are low, `in_ready` is high, and big-endian order applies until the first start-of-frame acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Double word offered |
| in_ready | output | 1 | Double word can be accepted |
| in_data | input | 64 | Double word, byte 0 in bits 7:0 |
| in_sof | input | 1 | Double word starts a frame |
| in_eof | input | 1 | Double word ends a frame |
| in_nbytes | input | 4 | Valid byte count on an end-of-frame word |
| mode_sel | input | 2 | Byte ordering mode: 00 swapped, 01 munged, 1x big-endian |
| port_is_32 | input | 1 | Memory port is 32 bits wide |
| out_valid | output | 1 | Byte offered |
| out_ready | input | 1 | Transmitter takes the byte |
| out_byte | output | 8 | Outgoing byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| cfg_err | output | 1 | Swapped order requested on a port that is not 32 bits |

## Verification
Random double words are sent in each of the three orders, so a swapped lane pair or a reversed half shows up as a wrong byte at a known position. The mode input is changed in the middle of a frame, and swapped order is requested on a non-32-bit port, to separate a frame-start sample from a live one. Single-word frames with counts of 1, 5, 0, 8 and 12, and garbage counts on middle words, test the truncation and the marker placement. The ready input is driven always high, random, and mostly low, so that stalls, loss and duplication are seen against the queued model.

// File: rtl/bos_pkg.sv
package bos_pkg;
  typedef enum logic [1:0] {
    ORD_BE    = 2'd0,
    ORD_SWAP  = 2'd1,
    ORD_MUNGE = 2'd2
  } ord_e;
endpackage

// File: rtl/bos_mode_ctrl.sv
// Frame-boundary sampling of the ordering mode and the port-size check.
module bos_mode_ctrl
  import bos_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [1:0] mode_sel,
  input  logic       port_is_32,
  output ord_e       ord_use,
  output logic       cfg_err
);
  ord_e ord_q, ord_d, ord_new;
  logic err_q, err_d, err_new;

  always_comb begin
    if (mode_sel[1])       ord_new = ORD_BE;
    else if (mode_sel[0])  ord_new = ORD_MUNGE;
    else if (port_is_32)   ord_new = ORD_SWAP;
    else                   ord_new = ORD_BE;
    err_new = (mode_sel == 2'b00) && !port_is_32;
    ord_d   = frame_start ? ord_new : ord_q;
    err_d   = frame_start ? err_new : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ord_q <= ORD_BE;
      err_q <= 1'b0;
    end else begin
      ord_q <= ord_d;
      err_q <= err_d;
    end
  end

  assign ord_use = ord_d;
  assign cfg_err = err_q;
endmodule

// File: rtl/bos_word_buf.sv
// Holds one double word and walks a byte index through it.
module bos_word_buf
  import bos_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [BYTE_W*LANES-1:0] ld_data,
  input  logic [$clog2(LANES)-1:0] ld_last,
  input  logic                    ld_sof,
  input  logic                    ld_eof,
  input  ord_e                    ld_ord,
  input  logic                    take,
  output logic                    busy,
  output logic [BYTE_W*LANES-1:0] data,
  output ord_e                    ord,
  output logic [$clog2(LANES)-1:0] idx,
  output logic                    sof,
  output logic                    eof,
  output logic                    at_last
);
  localparam int IDX_W = $clog2(LANES);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] last_q;

  assign at_last = (idx_q == last_q);

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (take) begin
      if (at_last) busy_d = 1'b0;
      else         idx_d  = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  // Payload registers: enable only, no reset needed.
  always_ff @(posedge clk) begin
    if (load) begin
      data   <= ld_data;
      last_q <= ld_last;
      sof    <= ld_sof;
      eof    <= ld_eof;
      ord    <= ld_ord;
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
endmodule

// File: rtl/bos_lane_sel.sv
// Maps an emission step to a byte lane for the active order.
module bos_lane_sel
  import bos_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 8
) (
  input  logic [BYTE_W*LANES-1:0]  data,
  input  ord_e                     ord,
  input  logic [$clog2(LANES)-1:0] idx,
  output logic [BYTE_W-1:0]        byte_out
);
  localparam int IDX_W = $clog2(LANES);
  localparam int HALF  = LANES / 2;

  logic [BYTE_W-1:0] lanes [LANES];
  logic [IDX_W-1:0]  sel;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = data[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    unique case (ord)
      ORD_SWAP:  sel = idx ^ IDX_W'(HALF);
      ORD_MUNGE: sel = idx;
      default:   sel = IDX_W'(LANES - 1) - idx;
    endcase
  end

  assign byte_out = lanes[sel];
endmodule

// File: rtl/byte_order_serializer.sv
module byte_order_serializer
  import bos_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [BYTE_W*LANES-1:0]       in_data,
  input  logic                          in_sof,
  input  logic                          in_eof,
  input  logic [$clog2(LANES+1)-1:0]    in_nbytes,
  input  logic [1:0]                    mode_sel,
  input  logic                          port_is_32,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [BYTE_W-1:0]             out_byte,
  output logic                          out_sof,
  output logic                          out_eof,
  output logic                          cfg_err
);
  localparam int DATA_W = BYTE_W * LANES;
  localparam int IDX_W  = $clog2(LANES);
  localparam int CNT_W  = $clog2(LANES + 1);

  logic              accept, take, busy, sof_q, eof_q, at_last;
  logic [CNT_W-1:0]  cnt_eff;
  logic [IDX_W-1:0]  last_idx, idx_q;
  logic [DATA_W-1:0] data_q;
  ord_e              ord_use, ord_q;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign take     = out_valid && out_ready;

  always_comb begin
    if (!in_eof || in_nbytes == '0 || in_nbytes > CNT_W'(LANES))
      cnt_eff = CNT_W'(LANES);
    else
      cnt_eff = in_nbytes;
    last_idx = IDX_W'(cnt_eff - CNT_W'(1));
  end

  bos_mode_ctrl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (accept && in_sof),
    .mode_sel    (mode_sel),
    .port_is_32  (port_is_32),
    .ord_use     (ord_use),
    .cfg_err     (cfg_err)
  );

  bos_word_buf #(.BYTE_W(BYTE_W), .LANES(LANES)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .ld_data (in_data),
    .ld_last (last_idx),
    .ld_sof  (in_sof),
    .ld_eof  (in_eof),
    .ld_ord  (ord_use),
    .take    (take),
    .busy    (busy),
    .data    (data_q),
    .ord     (ord_q),
    .idx     (idx_q),
    .sof     (sof_q),
    .eof     (eof_q),
    .at_last (at_last)
  );

  bos_lane_sel #(.BYTE_W(BYTE_W), .LANES(LANES)) u_sel (
    .data     (data_q),
    .ord      (ord_q),
    .idx      (idx_q),
    .byte_out (out_byte)
  );

  assign out_valid = busy;
  assign out_sof   = busy && sof_q && (idx_q == '0);
  assign out_eof   = busy && eof_q && at_last;
endmodule

// File: rtl/bos_checker.sv
module bos_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_sof,
  input logic [1:0]        mode_sel,
  input logic              port_is_32,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_byte,
  input logic              out_sof,
  input logic              out_eof,
  input logic              cfg_err
);
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte)
                               && $stable(out_sof) && $stable(out_eof));

  p_accept_shows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && !in_ready);

  p_drain_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eof |=> !out_valid && in_ready);

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(in_valid && in_ready && in_sof
                             && mode_sel == 2'b00 && !port_is_32));

  p_err_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && in_ready && in_sof) |-> $stable(cfg_err));

  p_sof_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_sof |=> out_sof);
endmodule

bind byte_order_serializer bos_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_sof     (in_sof),
  .mode_sel   (mode_sel),
  .port_is_32 (port_is_32),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_byte   (out_byte),
  .out_sof    (out_sof),
  .out_eof    (out_eof),
  .cfg_err    (cfg_err)
);

// File: tb/byte_order_serializer_tb.sv
module byte_order_serializer_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk, rst_n;
  logic        in_valid, in_ready, in_sof, in_eof, port_is_32;
  logic [63:0] in_data;
  logic [3:0]  in_nbytes;
  logic [1:0]  mode_sel;
  logic        out_valid, out_ready, out_sof, out_eof, cfg_err;
  logic [7:0]  out_byte;

  byte_order_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_nbytes(in_nbytes),
    .mode_sel(mode_sel), .port_is_32(port_is_32), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .out_sof(out_sof),
    .out_eof(out_eof), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct { logic [7:0] b; logic s; logic e; } exp_t;
  exp_t  expq[$];
  int    checks = 0, errors = 0, rdy_mode = 0, cyc = 0;
  string cur_tag = "R1";
  int    m_ord = 0;   // 0 big-endian, 1 swapped, 2 munged
  logic  m_err = 1'b0;

  // staged inputs, applied at the falling edge
  logic        st_valid = 1'b0, st_sof = 1'b0, st_eof = 1'b0, st_p32 = 1'b1;
  logic [63:0] st_data = '0;
  logic [3:0]  st_nb = '0;
  logic [1:0]  st_mode = 2'b10;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_push();
    int n, li;
    if (in_sof) begin
      if (mode_sel[1])      m_ord = 0;
      else if (mode_sel[0]) m_ord = 2;
      else if (port_is_32)  m_ord = 1;
      else                  m_ord = 0;
      m_err = (mode_sel == 2'b00) && !port_is_32;
    end
    n = (!in_eof || in_nbytes == 0 || in_nbytes > 8) ? 8 : int'(in_nbytes);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      li = (m_ord == 0) ? 7 - k : (m_ord == 1) ? (k ^ 4) : k;
      e.b = in_data[li*8 +: 8];
      e.s = in_sof && (k == 0);
      e.e = in_eof && (k == n - 1);
      expq.push_back(e);
    end
  endtask

  task automatic step();
    exp_t e;
    @(negedge clk);
    cyc++;
    in_valid = st_valid; in_data = st_data; in_sof = st_sof; in_eof = st_eof;
    in_nbytes = st_nb; mode_sel = st_mode; port_is_32 = st_p32;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'($urandom_range(0, 1));
      default: out_ready = ($urandom_range(0, 3) == 0);
    endcase
    #1;
    chk(in_ready === !out_valid, "R8", "in_ready vs pending", in_ready, !out_valid);
    chk(cfg_err === m_err, "R5", "cfg_err", cfg_err, m_err);
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R7", "unexpected byte", out_byte, 0);
      end else begin
        e = expq.pop_front();
        chk(out_byte === e.b, cur_tag, "byte", out_byte, e.b);
        chk(out_sof === e.s, "R6", "out_sof", out_sof, e.s);
        chk(out_eof === e.e, "R6", "out_eof", out_eof, e.e);
      end
    end
    if (in_valid && in_ready) begin
      model_push();
      st_valid = 1'b0;
    end
  endtask

  task automatic send_word(input logic sof, input logic eof, input logic [3:0] nb);
    st_data  = {$urandom, $urandom};
    st_sof   = sof; st_eof = eof; st_nb = nb;
    st_valid = 1'b1;
    while (st_valid) step();
  endtask

  task automatic send_frame(input logic [1:0] mode, input logic p32, input int nw,
                            input logic [3:0] lastn, input int mid_mode);
    st_mode = mode; st_p32 = p32;
    for (int w = 0; w < nw; w++) begin
      if (w == 1 && mid_mode >= 0) begin st_mode = 2'(mid_mode); st_p32 = !p32; end
      send_word(w == 0, w == nw - 1, (w == nw - 1) ? lastn : 4'd3);
    end
  endtask

  task automatic drain();
    int guard = 0;
    while ((expq.size() != 0 || out_valid) && guard < 400) begin step(); guard++; end
    chk(expq.size() == 0, cur_tag, "bytes left over", expq.size(), 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
    in_nbytes = '0; mode_sel = 2'b10; port_is_32 = 1'b1; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid === 1'b0, "R9", "reset out_valid", out_valid, 0);
    chk(in_ready === 1'b1, "R9", "reset in_ready", in_ready, 1);
    chk(cfg_err === 1'b0, "R9", "reset cfg_err", cfg_err, 0);
    @(negedge clk); rst_n = 1'b1;

    // R9: before any start of frame the order is big-endian, mode ignored
    cur_tag = "R9"; st_mode = 2'b01;
    send_word(1'b0, 1'b0, 4'd0); drain();

    cur_tag = "R1";
    send_frame(2'b10, 1'b1, 3, 4'd8, -1); drain();
    send_frame(2'b11, 1'b0, 2, 4'd8, -1); drain();
    cur_tag = "R2";
    send_frame(2'b00, 1'b1, 3, 4'd8, -1); drain();
    cur_tag = "R3";
    send_frame(2'b01, 1'b1, 3, 4'd8, -1); drain();

    // R4: mode and port size changed mid-frame, then taken at next frame
    cur_tag = "R4";
    send_frame(2'b01, 1'b1, 3, 4'd8, 2);   drain();
    send_frame(2'b10, 1'b1, 2, 4'd8, 0);   drain();
    send_word(1'b1, 1'b1, 4'd8);           drain();

    // R5: swapped on a non-32-bit port falls back and flags, then clears
    cur_tag = "R5";
    send_frame(2'b00, 1'b0, 3, 4'd8, -1); drain();
    send_frame(2'b01, 1'b1, 2, 4'd8, -1); drain();

    // R6: byte counts on single-word frames in every order
    cur_tag = "R6";
    for (int m = 0; m < 3; m++) begin
      send_frame(2'(m), 1'b1, 1, 4'd1, -1);  drain();
      send_frame(2'(m), 1'b1, 1, 4'd5, -1);  drain();
      send_frame(2'(m), 1'b1, 1, 4'd0, -1);  drain();
      send_frame(2'(m), 1'b1, 1, 4'd12, -1); drain();
      send_frame(2'(m), 1'b1, 4, 4'd3, -1);  drain();
    end

    // R7: back-pressure, random and mostly stalled
    cur_tag = "R7";
    for (int r = 1; r < 3; r++) begin
      rdy_mode = r;
      for (int m = 0; m < 4; m++) begin
        send_frame(2'(m), 1'(m != 0 || r == 1), 3, 4'(m + 2), -1);
      end
      drain();
    end
    rdy_mode = 0;
    repeat (4) step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule